// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Register

This block turns a slow serial bit stream into a parallel word. A serial clock and a data line feed a shift register, one bit on each rising edge of the serial clock. A separate store strobe copies the whole shift register into an output register, and only that output register drives the parallel outputs. Downstream logic therefore sees a complete word change all at once, and never the intermediate values while bits move through.

The serial clock, the store strobe and the data line arrive without any timing relation to the system clock. Each one passes through the same synchroniser chain into the system clock domain. The block detects rising edges there by comparing each synchronised level with a copy delayed by one cycle. The top stage of the shift register is brought out as a serial output. Connecting it to the data input of a second unit, with both units sharing the serial clock and the strobe, gives one longer register.

Top module: `latched_sipo`

## Requirements
- R1: While `rst_n` is low at a system clock edge, both the shift register and the output register are cleared to zero, so `par_out` and `ser_out` read 0.
- R2: On each detected rising edge of `ser_clk_in`, the shift register moves every bit up one place. Bit 0 takes the sampled `ser_data_in`, and the old bit WIDTH-1 is discarded. A word sent most significant bit first therefore lands in its natural bit order.
- R3: `ser_out` always equals the current top bit (bit WIDTH-1) of the shift register.
- R4: Without a strobe rising edge, `par_out` keeps its value, however many bits are shifted in.
- R5: On a detected rising edge of `store_in`, the full shift register contents are copied into the output register in a single step.
- R6: When `ser_clk_in` and `store_in` rise in the same system cycle, the output register captures the shift register as it was before that shift.
- R7: Only rising edges act. Holding `ser_clk_in` or `store_in` high for many cycles, or letting it fall, causes no further shift or capture.
- R8: Two units in a chain (the first unit's `ser_out` drives the second unit's `ser_data_in`, with shared clock, strobe and reset) behave as one register of 2*WIDTH bits. The second unit holds the upper half.
- R9: A reset asserted partway through a transfer discards the bits shifted in so far. A later strobe with no new bits presents zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk_in | input | 1 | Asynchronous serial clock; each rising edge shifts one bit |
| ser_data_in | input | 1 | Asynchronous serial data, sampled on the serial clock edge |
| store_in | input | 1 | Asynchronous store strobe; each rising edge loads the output register |
| par_out | output | WIDTH | Parallel word from the output register |
| ser_out | output | 1 | Top bit of the shift register, used for chaining |

## Verification
The bench builds two units with the default WIDTH of 8 and SYNC_STAGES of 2, with the first unit's serial output feeding the second unit's data input. With this chain, a 16-bit reference model follows every shift and strobe. Bits that fall off the top of the lower unit then show up as correct bits in the upper unit, which a single 8-bit instance cannot show. The short synchroniser depth keeps each serial clock pulse to a few system cycles. This makes long sequences cheap, such as shifting sixteen bits, or a strobe held high across several shifts. It also makes it possible to drive the serial clock and the strobe in the same cycle for the lag case.

// File: rtl/sipo_pkg.sv
// Package: shared control bundle between the input front end and the
// register stages of the latched serial-to-parallel block.
package sipo_pkg;

    // Per-cycle control derived from the synchronised inputs.
    typedef struct packed {
        logic shift_pulse;  // one-cycle pulse on a serial clock rise
        logic store_pulse;  // one-cycle pulse on a store strobe rise
        logic data;         // serial data, aligned with shift_pulse
    } sipo_ctrl_t;

endpackage

// File: rtl/sipo_sync.sv
// Module: sipo_sync
// Brings one asynchronous level into the clk domain through a chain of
// STAGES flops. Assumes STAGES >= 2. The output lags the input by STAGES
// system cycles and resets to 0.
module sipo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // First stage: capture the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    // Remaining stages: each copies the stage below it.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/sipo_edge_detect.sv
// Module: sipo_edge_detect
// Synchronises one asynchronous control line. It then produces a one-cycle
// pulse in the first cycle in which the synchronised level is high after
// being low. Assumes the line stays at each level for at least two
// system cycles.
module sipo_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise
);
    logic level;
    logic level_d;

    sipo_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (level)
    );

    // Delayed copy of the synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

    // A rise can never be reported in two consecutive cycles.
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);  // R7

endmodule

// File: rtl/sipo_shift_reg.sv
// Module: sipo_shift_reg
// WIDTH-bit shift register. On an enable pulse it moves every bit up one
// place and loads din into bit 0. It holds its contents otherwise. Assumes
// WIDTH >= 2.
module sipo_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             top_bit
);
    localparam int TOP = WIDTH - 1;

    // Shift on a pulse, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[TOP-1:0], din};
    end

    assign top_bit = q[TOP];

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[TOP:1] == $past(q[TOP-1:0])) && (q[0] == $past(din)));  // R2
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));  // R7

endmodule

// File: rtl/sipo_store_reg.sv
// Module: sipo_store_reg
// Output register in front of the parallel pins. Loads the whole
// shift register on a capture pulse and holds it otherwise.
module sipo_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Whole-word load on capture, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= d;
    end

    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> q == $past(d));  // R5
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q));  // R4
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> q == '0);  // R1

endmodule

// File: rtl/latched_sipo.sv
// Module: latched_sipo
// Top of the latched serial-to-parallel output register. It synchronises the
// serial clock, the store strobe and the data line with equal latency, so
// the data is aligned with the serial clock edge. It shifts on serial clock
// rises and loads the output register on strobe rises. Assumes every input
// level lasts at least two system cycles and that the data is steady for
// SYNC_STAGES cycles before a serial clock rise.
module latched_sipo #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_in,
    input  logic             ser_data_in,
    input  logic             store_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);
    import sipo_pkg::*;

    sipo_ctrl_t       ctrl;
    logic [WIDTH-1:0] shift_q;
    logic             data_sync;
    logic             data_d;

    sipo_edge_detect #(.STAGES(SYNC_STAGES)) u_clk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ser_clk_in),
        .rise    (ctrl.shift_pulse)
    );

    sipo_edge_detect #(.STAGES(SYNC_STAGES)) u_store_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (store_in),
        .rise    (ctrl.store_pulse)
    );

    sipo_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ser_data_in),
        .q     (data_sync)
    );

    // Data is held back one extra cycle to match the edge compare flop.
    always_ff @(posedge clk) begin
        if (!rst_n) data_d <= 1'b0;
        else        data_d <= data_sync;
    end

    assign ctrl.data = data_d;

    sipo_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ctrl.shift_pulse),
        .din      (ctrl.data),
        .q        (shift_q),
        .top_bit  (ser_out)
    );

    sipo_store_reg #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (ctrl.store_pulse),
        .d      (shift_q),
        .q      (par_out)
    );

    // A capture that coincides with a shift takes the pre-shift word.
    AST_SAME_EDGE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.shift_pulse && ctrl.store_pulse) |=> par_out == $past(shift_q));  // R6

endmodule

// File: tb/latched_sipo_bench.sv
// Bench: directed scenarios on a two-unit chain. A 16-bit reference model
// tracks every shift and strobe.
module latched_sipo_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk_in = 1'b0;
    logic         ser_data_in = 1'b0;
    logic         store_in = 1'b0;
    logic [W-1:0] par_lo, par_hi;
    logic         ser_lo, ser_hi;

    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    logic [15:0]  ref_shift = '0;
    logic [15:0]  ref_par = '0;

    always #10 clk = ~clk;

    latched_sipo #(.WIDTH(W), .SYNC_STAGES(2)) u_latched_sipo (
        .clk(clk), .rst_n(rst_n), .ser_clk_in(ser_clk_in),
        .ser_data_in(ser_data_in), .store_in(store_in),
        .par_out(par_lo), .ser_out(ser_lo)
    );

    latched_sipo #(.WIDTH(W), .SYNC_STAGES(2)) u_latched_sipo_hi (
        .clk(clk), .rst_n(rst_n), .ser_clk_in(ser_clk_in),
        .ser_data_in(ser_lo), .store_in(store_in),
        .par_out(par_hi), .ser_out(ser_hi)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        ref_shift = '0;
        ref_par = '0;
        idle(2);
    endtask

    // One serial bit: data settles first, then a clean clock pulse.
    task automatic send_bit(input logic b);
        ser_data_in = b;
        idle(3);
        ser_clk_in = 1'b1;
        idle(4);
        ser_clk_in = 1'b0;
        idle(4);
        ref_shift = {ref_shift[14:0], b};
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_store();
        store_in = 1'b1;
        idle(4);
        store_in = 1'b0;
        idle(4);
        ref_par = ref_shift;
    endtask

    task automatic check_outputs(input string req);
        check(req, "par_lo", {8'h00, par_lo}, {8'h00, ref_par[7:0]});
        check(req, "par_hi", {8'h00, par_hi}, {8'h00, ref_par[15:8]});
        check(req, "ser_lo", {15'h0, ser_lo}, {15'h0, ref_shift[7]});
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1", "par_lo after reset", {8'h00, par_lo}, 16'h0000);
        check("R1", "ser_lo after reset", {15'h0, ser_lo}, 16'h0000);
        check("R1", "par_hi after reset", {8'h00, par_hi}, 16'h0000);
    endtask

    task automatic t_shift_and_store();
        send_byte(8'hA5);
        check("R4", "par_lo before strobe", {8'h00, par_lo}, 16'h0000);
        check("R3", "ser_lo shows top bit", {15'h0, ser_lo}, 16'h0001);
        pulse_store();
        check("R2", "par_lo word order", {8'h00, par_lo}, 16'h00A5);
        check("R5", "par_lo after strobe", {8'h00, par_lo}, {8'h00, ref_par[7:0]});
    endtask

    task automatic t_hold_while_shifting();
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        check("R4", "par_lo held during shifts", {8'h00, par_lo}, 16'h00A5);
        check("R3", "ser_lo tracks shifts", {15'h0, ser_lo}, {15'h0, ref_shift[7]});
    endtask

    task automatic t_level_only_edges();
        // Long high level on the serial clock: exactly one shift.
        ser_data_in = 1'b1;
        idle(3);
        ser_clk_in = 1'b1;
        idle(20);
        ser_clk_in = 1'b0;
        idle(20);
        ref_shift = {ref_shift[14:0], 1'b1};
        pulse_store();
        check("R7", "one shift per long clock pulse", {8'h00, par_lo}, {8'h00, ref_par[7:0]});
        // Strobe held high across shifts: no recapture.
        store_in = 1'b1;
        idle(4);
        ref_par = ref_shift;
        send_bit(1'b0);
        send_bit(1'b1);
        check("R7", "held strobe does not recapture", {8'h00, par_lo}, {8'h00, ref_par[7:0]});
        store_in = 1'b0;
        idle(6);
        check("R7", "strobe fall does not capture", {8'h00, par_lo}, {8'h00, ref_par[7:0]});
    endtask

    task automatic t_same_edge();
        send_byte(8'h3C);
        pulse_store();
        ser_data_in = 1'b1;
        idle(3);
        ser_clk_in = 1'b1;
        store_in = 1'b1;
        idle(4);
        ser_clk_in = 1'b0;
        store_in = 1'b0;
        idle(4);
        check("R6", "same-edge capture is pre-shift", {8'h00, par_lo}, 16'h003C);
        ref_shift = {ref_shift[14:0], 1'b1};
        pulse_store();
        check("R6", "next strobe shows lagged bit", {8'h00, par_lo}, 16'h0079);
    endtask

    task automatic t_chain();
        send_byte(8'hBE);
        send_byte(8'hEF);
        pulse_store();
        check("R8", "chain 16-bit word", {par_hi, par_lo}, 16'hBEEF);
        check("R8", "chain upper serial out", {15'h0, ser_hi}, {15'h0, ref_shift[15]});
        check_outputs("R8");
    endtask

    task automatic t_reset_mid();
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        apply_reset();
        pulse_store();
        check("R9", "strobe after mid reset", {par_hi, par_lo}, 16'h0000);
        check("R9", "ser_lo after mid reset", {15'h0, ser_lo}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_shift_and_store();
        t_hold_while_shifting();
        t_level_only_edges();
        t_same_edge();
        t_chain();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule